// File: doc/BRIEF.md
# Power-Up Strap Capture and Frequency Code Selector

This block runs the power-up sequence of a clock generator's shared pins. From reset until power is good, five shared pads are read as configuration straps: three frequency-select bits, a mode bit and a CPU supply-level bit. The first cycle on which the power-good input is seen high after reset captures the pad levels into strap registers. They are captured once only.

One cycle after the capture, the pads become outputs and are held low. A power-up timer on the reference clock then counts a fixed number of cycles. When it expires, a single enable output tells the clock output stage that it may toggle.

The frequency code comes from one of two sources. The latched hardware straps supply it by default. A select bit in configuration byte 0 moves the choice to a software field in the same byte. The mode and supply-level straps are passed out unchanged for the rest of the chip. All pins are plain control and status signals, so the block has no streaming interface and no back-pressure.

Top module: `pwrup_strap_ctrl`

## Requirements
- R1: While `rst_n` is low, and until a capture happens, `pad_oe`, `clk_out_en`, `pad_force_low` and `strap_latched` are 0. `mode_strap` and `vsel_strap` are 1, and the hardware frequency straps read 3'b111, which is the level the pull-ups give. With `cfg0[3]`=0, `freq_code` is therefore 3'b111.
- R2: Capture happens at the first rising clock edge after reset release on which `pwr_good` is 1. It stores `strap_pad[2:0]` as the frequency straps, `strap_pad[3]` as mode and `strap_pad[4]` as supply level, and it sets `strap_latched`. All of these are visible right after that edge.
- R3: After capture, the strap values never change again, whatever `strap_pad` and `pwr_good` do, until the next reset.
- R4: `pad_oe` stays 0 on the capture edge itself. It becomes 1 on the following edge and stays 1.
- R5: `clk_out_en` rises exactly TIMER_CYCLES rising edges after the capture edge. TIMER_CYCLES must be at least 2. The default is 42954, which is 3 ms at 14.318 MHz. Once set, `clk_out_en` stays 1.
- R6: `pad_force_low` is 1 exactly while `pad_oe` is 1 and `clk_out_en` is still 0.
- R7: When `cfg0[3]`=0, `freq_code` equals the latched `strap_pad[2:0]`.
- R8: When `cfg0[3]`=1, `freq_code` equals `cfg0[6:4]`, and the other bits of `cfg0` have no effect on it.
- R9: `mode_strap` reports the latched `strap_pad[3]`, where 1 means the two dual-use pins are clock outputs. `vsel_strap` reports the latched `strap_pad[4]`, where 1 means 2.5 V CPU supply and 0 means 3.3 V.
- R10: When `pwr_good` falls after capture, `pad_oe`, the timer and `clk_out_en` are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply above threshold |
| strap_pad | input | 5 | Pad input levels {vsel, mode, fs[2:0]} |
| cfg0 | input | 8 | Configuration byte 0; bit 3 selects the source, bits 6:4 are the software code |
| pad_oe | output | 1 | Shared pads drive (1) or are inputs (0) |
| pad_force_low | output | 1 | Shared pads held low |
| clk_out_en | output | 1 | Power-up timer expired; clocks may toggle |
| strap_latched | output | 1 | Straps have been captured |
| freq_code | output | 3 | Selected frequency code |
| mode_strap | output | 1 | Latched mode strap |
| vsel_strap | output | 1 | Latched supply-level strap |

## Verification
A strap register that reloads, or one that never loads, shows up on `mode_strap`, `vsel_strap` or `freq_code` on the cycle right after the offending edge. The bench changes the pads after capture to provoke exactly that. A timer that is off by one cycle moves the rise of `clk_out_en` by one cycle. The bench therefore samples one cycle before the expected rise and one cycle at it. A wrong direction-control flop shows up as `pad_oe` high on the capture edge or during reset. A wrong mux polarity shows up at once on `freq_code` when `cfg0[3]` is toggled with straps and software field set to different values.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int STRAP_W = 5;
  localparam int FS_W    = 3;

  typedef struct packed {
    logic            vsel;
    logic            mode;
    logic [FS_W-1:0] fs;
  } strap_t;

  localparam strap_t STRAP_PULLUP = '{vsel: 1'b1, mode: 1'b1, fs: '1};

  localparam int CFG_SRC_BIT = 3;
  localparam int CFG_SW_LSB  = 4;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_good,
  input  logic [STRAP_W-1:0] pad_in,
  output strap_t             straps,
  output logic               latched,
  output logic               oe
);
  logic   pg_seen;
  logic   take;

  assign take = pwr_good & ~pg_seen & ~latched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_seen <= 1'b0;
      latched <= 1'b0;
      oe      <= 1'b0;
      straps  <= STRAP_PULLUP;
    end else begin
      pg_seen <= pwr_good;
      oe      <= latched;
      if (take) begin
        straps  <= strap_t'(pad_in);
        latched <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int CYCLES = 42954
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (start && !done) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end
endmodule

// File: rtl/freq_sel.sv
module freq_sel
  import strap_pkg::*;
(
  input  logic [7:0]      cfg,
  input  logic [FS_W-1:0] hw_fs,
  output logic [FS_W-1:0] code
);
  always_comb begin
    if (cfg[CFG_SRC_BIT]) code = cfg[CFG_SW_LSB +: FS_W];
    else                  code = hw_fs;
  end
endmodule

// File: rtl/pwrup_strap_ctrl.sv
module pwrup_strap_ctrl
  import strap_pkg::*;
#(
  parameter int TIMER_CYCLES = 42954
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_good,
  input  logic [STRAP_W-1:0] strap_pad,
  input  logic [7:0]         cfg0,
  output logic               pad_oe,
  output logic               pad_force_low,
  output logic               clk_out_en,
  output logic               strap_latched,
  output logic [FS_W-1:0]    freq_code,
  output logic               mode_strap,
  output logic               vsel_strap
);
  strap_t straps;

  strap_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_good(pwr_good),
    .pad_in  (strap_pad),
    .straps  (straps),
    .latched (strap_latched),
    .oe      (pad_oe)
  );

  pwrup_timer #(.CYCLES(TIMER_CYCLES)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .start(strap_latched),
    .done (clk_out_en)
  );

  freq_sel u_sel (
    .cfg  (cfg0),
    .hw_fs(straps.fs),
    .code (freq_code)
  );

  assign pad_force_low = pad_oe & ~clk_out_en;
  assign mode_strap    = straps.mode;
  assign vsel_strap    = straps.vsel;
endmodule

// File: rtl/pwrup_strap_chk.sv
module pwrup_strap_chk #(
  parameter int TIMER_CYCLES = 42954
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic [4:0] strap_pad,
  input logic [7:0] cfg0,
  input logic       pad_oe,
  input logic       pad_force_low,
  input logic       clk_out_en,
  input logic       strap_latched,
  input logic [2:0] freq_code,
  input logic       mode_strap,
  input logic       vsel_strap
);
  localparam int CW = $clog2(TIMER_CYCLES + 2) + 1;
  logic [CW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (strap_latched && since != '1) since <= since + 1'b1;
  end

  // R3: captured straps never change again
  a_r3_no_relatch: assert property (@(posedge clk) disable iff (!rst_n)
    strap_latched && $past(strap_latched) |-> $stable(mode_strap) && $stable(vsel_strap));

  a_r3_hw_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
    strap_latched && $past(strap_latched) && !cfg0[3] && !$past(cfg0[3]) |-> $stable(freq_code));

  // R4: the pads only drive after capture, and keep driving
  a_r4_oe_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_oe) |-> $past(strap_latched));

  a_r4_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pad_oe) |-> 1'b0 == 1'b1);

  // R5: expiry lands exactly TIMER_CYCLES edges after capture
  a_r5_timer_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out_en) |-> since == CW'(TIMER_CYCLES));

  a_r5_en_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out_en |-> pad_oe);

  // R6: the hold-low phase and toggling exclude each other
  a_r6_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    pad_force_low |-> !clk_out_en && pad_oe);

  // R8: in software mode the code follows the configuration field
  a_r8_sw_code: assert property (@(posedge clk) disable iff (!rst_n)
    cfg0[3] |-> freq_code == cfg0[6:4]);
endmodule

bind pwrup_strap_ctrl pwrup_strap_chk #(.TIMER_CYCLES(TIMER_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_good     (pwr_good),
  .strap_pad    (strap_pad),
  .cfg0         (cfg0),
  .pad_oe       (pad_oe),
  .pad_force_low(pad_force_low),
  .clk_out_en   (clk_out_en),
  .strap_latched(strap_latched),
  .freq_code    (freq_code),
  .mode_strap   (mode_strap),
  .vsel_strap   (vsel_strap)
);

// File: tb/tb_pwrup_strap_ctrl.sv
module tb_pwrup_strap_ctrl;
  localparam int T = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_good = 1'b0;
  logic [4:0] strap_pad = 5'b11111;
  logic [7:0] cfg0 = 8'h00;
  logic       pad_oe, pad_force_low, clk_out_en, strap_latched;
  logic [2:0] freq_code;
  logic       mode_strap, vsel_strap;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwrup_strap_ctrl #(.TIMER_CYCLES(T)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_pad(strap_pad),
    .cfg0(cfg0), .pad_oe(pad_oe), .pad_force_low(pad_force_low),
    .clk_out_en(clk_out_en), .strap_latched(strap_latched),
    .freq_code(freq_code), .mode_strap(mode_strap), .vsel_strap(vsel_strap)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(logic [4:0] pads);
    @(negedge clk);
    rst_n = 1'b0; pwr_good = 1'b0; cfg0 = 8'h00; strap_pad = pads;
    step(3);
    rst_n = 1'b1;
    step(2);
  endtask

  // drives pwr_good high at a negedge; the next posedge is the capture edge
  task automatic power_good_now();
    pwr_good = 1'b1;
    step(1);
  endtask

  task automatic t_reset_state();
    do_reset(5'b00000);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 clk_out_en", clk_out_en, 0);
    chk("R1 pad_force_low", pad_force_low, 0);
    chk("R1 strap_latched", strap_latched, 0);
    chk("R1 mode_strap", mode_strap, 1);
    chk("R1 vsel_strap", vsel_strap, 1);
    chk("R1 freq_code", freq_code, 7);
  endtask

  task automatic t_capture_and_timer();
    do_reset(5'b01101);
    power_good_now();
    chk("R2 latched", strap_latched, 1);
    chk("R7 hw fs", freq_code, 5);
    chk("R9 mode", mode_strap, 1);
    chk("R9 vsel", vsel_strap, 0);
    chk("R4 oe on capture edge", pad_oe, 0);
    step(1);
    chk("R4 oe next edge", pad_oe, 1);
    chk("R6 force low", pad_force_low, 1);
    step(T - 2);
    chk("R5 not yet", clk_out_en, 0);
    chk("R6 force low before expiry", pad_force_low, 1);
    step(1);
    chk("R5 expired", clk_out_en, 1);
    chk("R6 force low released", pad_force_low, 0);
    step(5);
    chk("R5 sticky", clk_out_en, 1);
  endtask

  task automatic t_no_relatch();
    do_reset(5'b10010);
    power_good_now();
    strap_pad = 5'b01101;
    pwr_good = 1'b0; step(2);
    pwr_good = 1'b1; step(2);
    chk("R3 fs kept", freq_code, 2);
    chk("R3 mode kept", mode_strap, 0);
    chk("R3 vsel kept", vsel_strap, 1);
  endtask

  task automatic t_sw_select();
    do_reset(5'b11011);
    power_good_now();
    cfg0 = 8'b0100_1000;
    step(1);
    chk("R8 sw code 4", freq_code, 4);
    cfg0 = 8'b1001_1111;
    step(1);
    chk("R8 sw code 1 other bits", freq_code, 1);
    cfg0 = 8'b1111_0111;
    step(1);
    chk("R7 back to hw", freq_code, 3);
  endtask

  task automatic t_pg_drop();
    do_reset(5'b00000);
    power_good_now();
    step(3);
    pwr_good = 1'b0;
    step(2);
    chk("R10 oe held", pad_oe, 1);
    step(T);
    chk("R10 timer ran", clk_out_en, 1);
    chk("R2 zeros captured", freq_code, 0);
    chk("R9 mode zero", mode_strap, 0);
  endtask

  task automatic t_pg_high_at_release();
    @(negedge clk);
    rst_n = 1'b0; strap_pad = 5'b10110; pwr_good = 1'b1; cfg0 = 8'h00;
    step(2);
    chk("R1 no capture in reset", strap_latched, 0);
    rst_n = 1'b1;
    step(1);
    chk("R2 capture first edge", strap_latched, 1);
    chk("R2 fs", freq_code, 6);
    chk("R9 vsel 2.5V", vsel_strap, 1);
  endtask

  initial begin
    t_reset_state();
    t_capture_and_timer();
    t_no_relatch();
    t_sw_select();
    t_pg_drop();
    t_pg_high_at_release();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule